// File: doc/BRIEF.md
# Interrupt Stacking and Return Sequencer

This block sits beside a small 8-bit CPU core and takes over the memory bus at instruction boundaries. When the core reports that an instruction has finished, the sequencer looks at the pending interrupt sources. If one is enabled and the condition-code mask bit is clear, it runs a fixed entry sequence. The sequence saves the return address, X, A and the condition codes on a stack that grows downward, reads a two-byte handler vector, sets the mask bit and fetches the first handler opcode. The index-high register is never stacked.

When the core decodes a return-from-interrupt, it raises a request and the sequencer runs the matching pull sequence. It restores the condition codes, A, X and the program counter from ascending stack addresses, then prefetches the opcode at the restored address. In that prefetch cycle it checks the interrupt sources again. If a source can be taken, the opcode is dropped and the sequencer goes straight into a new entry. The core therefore services chained interrupts before it executes any instruction at the return address. Register values flow through load strobes: the core copies `x_o` into X when `x_ld_o` is high, and does the same for the other registers.

Top module: `intr_stack_seq`

## Requirements
- R1: While idle, with neither `insn_done_i` nor `rti_i` high, the block stays idle. While idle it drives `busy_o`=0, `done_o`=0, `rw_o`=1 (1 = read, 0 = write) and `addr_o`=0.
- R2: An entry starts after an idle cycle with `insn_done_i`=1 only if some source n has both `irq_req_i[n]` and `irq_en_i[n]` set and `ccr_i` bit 3 (the mask bit) is 0. Otherwise the block stays idle.
- R3: Among takeable sources the lowest index wins. Its vector high byte is read at VEC_BASE-2n and its low byte at VEC_BASE-2n+1 (default VEC_BASE 0xFFFC).
- R4: Entry begins with one read at SP. Five writes follow: (PC-1) low byte at SP, (PC-1) high byte at SP-1, X at SP-2, A at SP-3 and CCR at SP-4. The CCR written is the value before masking.
- R5: After the two vector reads, the block reads the opcode at the address the vector bytes form. In that cycle it also asserts `pc_ld_o` with `pc_o` equal to that address.
- R6: In the cycle that writes CCR, the block loads CCR with bit 3 set and the other bits kept, and loads SP with SP-5.
- R7: When `rti_i` is seen while idle, the block reads SP+1 to SP+5 in ascending order. It loads CCR, A and X from the first three reads and takes the PC high and low bytes from the last two. It loads SP+5 in the last pull cycle, then reads the opcode at the pulled address plus one and loads PC with that address.
- R8: In that return fetch cycle, if a source is takeable and bit 3 of the restored CCR is 0, `done_o` stays low. A full entry then runs with the restored registers, using SP+5 as its stack base. If the restored bit 3 is 1, the return completes normally.
- R9: `busy_o` is high in every cycle of a sequence: 9 cycles for entry and 6 for return. `done_o` pulses for exactly one cycle, in the final opcode fetch of the sequence.
- R10: All stack and vector address arithmetic wraps modulo 2^16.
- R11: When `rti_i` and `insn_done_i` are both high while idle, the return sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| insn_done_i | input | 1 | Current instruction has completed |
| rti_i | input | 1 | Return-from-interrupt requested |
| irq_req_i | input | N_SRC | Pending interrupt requests, index 0 highest priority |
| irq_en_i | input | N_SRC | Per-source enables |
| pc_i | input | 16 | Core PC (address of the next opcode) |
| sp_i | input | 16 | Core stack pointer |
| x_i | input | 8 | Core X register |
| a_i | input | 8 | Core accumulator |
| ccr_i | input | 8 | Core condition codes, bit 3 is the mask |
| addr_o | output | 16 | Bus address |
| wdata_o | output | 8 | Bus write data |
| rdata_i | input | 8 | Bus read data, valid in the same cycle |
| rw_o | output | 1 | 1 = read, 0 = write |
| pc_ld_o | output | 1 | Load PC strobe |
| pc_o | output | 16 | PC load value |
| x_ld_o | output | 1 | Load X strobe |
| x_o | output | 8 | X load value |
| a_ld_o | output | 1 | Load A strobe |
| a_o | output | 8 | A load value |
| ccr_ld_o | output | 1 | Load CCR strobe |
| ccr_o | output | 8 | CCR load value |
| sp_ld_o | output | 1 | Load SP strobe |
| sp_o | output | 16 | SP load value |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | First handler or resumed opcode fetched |

## Verification
The hardest case to reach is the chained entry. It happens only when the bytes pulled from the stack carry a clear mask bit while an enabled request is still pending at the return fetch. The bench gets there with round trips: it runs a random entry, replays the bytes the block wrote into a small stack model, issues a return, and keeps the request enabled on half of the trips. A directed return whose stacked CCR has the mask set covers the opposite branch.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_E_DUM, ST_E_PCL, ST_E_PCH, ST_E_X, ST_E_A, ST_E_CCR,
    ST_E_VH, ST_E_VL, ST_E_FET,
    ST_R_CCR, ST_R_A, ST_R_X, ST_R_PCH, ST_R_PCL, ST_R_FET
  } seq_st_e;

  localparam int unsigned FRAME_BYTES = 5;
endpackage

// File: rtl/intr_pick.sv
module intr_pick #(
  parameter int unsigned N_SRC = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] en_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N_SRC-1:0] pend;

  for (genvar g = 0; g < N_SRC; g++) begin : g_pend
    assign pend[g] = req_i[g] & en_i[g];
  end

  always_comb begin
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend[i]) idx_o = IDX_W'(i);
    end
  end

  assign valid_o = |pend;

  // no lower-numbered source may be pending besides the winner
  logic [N_SRC-1:0] below;
  assign below = pend & ((N_SRC'(1) << idx_o) - N_SRC'(1));

  always_comb begin
    if (valid_o) begin
      assert_pick_lowest_R3: assert (pend[idx_o] && below == '0);
    end
  end
endmodule

// File: rtl/intr_fsm.sv
module intr_fsm
  import intr_seq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_ent_i,
  input  logic    start_ret_i,
  input  logic    chain_i,
  output seq_st_e state_o
);
  seq_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_ret_i) st_d = ST_R_CCR;
                else if (start_ent_i) st_d = ST_E_DUM;
      ST_E_FET: st_d = ST_IDLE;
      ST_R_FET: st_d = chain_i ? ST_E_DUM : ST_IDLE;
      default:  st_d = seq_st_e'(st_q + 4'd1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/intr_stack_seq.sv
module intr_stack_seq
  import intr_seq_pkg::*;
#(
  parameter int unsigned N_SRC    = 4,
  parameter int unsigned DW       = 8,
  parameter logic [15:0] VEC_BASE = 16'hFFFC,
  parameter int unsigned I_BIT    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             insn_done_i,
  input  logic             rti_i,
  input  logic [N_SRC-1:0] irq_req_i,
  input  logic [N_SRC-1:0] irq_en_i,
  input  logic [15:0]      pc_i,
  input  logic [15:0]      sp_i,
  input  logic [DW-1:0]    x_i,
  input  logic [DW-1:0]    a_i,
  input  logic [DW-1:0]    ccr_i,
  output logic [15:0]      addr_o,
  output logic [DW-1:0]    wdata_o,
  input  logic [DW-1:0]    rdata_i,
  output logic             rw_o,
  output logic             pc_ld_o,
  output logic [15:0]      pc_o,
  output logic             x_ld_o,
  output logic [DW-1:0]    x_o,
  output logic             a_ld_o,
  output logic [DW-1:0]    a_o,
  output logic             ccr_ld_o,
  output logic [DW-1:0]    ccr_o,
  output logic             sp_ld_o,
  output logic [15:0]      sp_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int unsigned AW    = 2 * DW;
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam logic [AW-1:0] FRAME = AW'(FRAME_BYTES);
  localparam logic [DW-1:0] MASK  = DW'(1) << I_BIT;

  seq_st_e st;
  logic pick_v, mask_now, take_irq, start_ent, start_ret, chain;
  logic [IDX_W-1:0] pick_idx;
  logic [AW-1:0] vec_addr, pc_m1;
  logic [AW-1:0] pc_q, sp_q, vec_q;
  logic [DW-1:0] x_q, a_q, ccr_q;

  intr_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) pick_i (
    .req_i(irq_req_i), .en_i(irq_en_i), .valid_o(pick_v), .idx_o(pick_idx)
  );

  // mask comes from the core at a boundary, from the pulled CCR on return
  assign mask_now  = (st == ST_IDLE) ? ccr_i[I_BIT] : ccr_q[I_BIT];
  assign take_irq  = pick_v && !mask_now;
  assign start_ret = (st == ST_IDLE) && rti_i;
  assign start_ent = (st == ST_IDLE) && !rti_i && insn_done_i && take_irq;
  assign chain     = (st == ST_R_FET) && take_irq;
  assign vec_addr  = VEC_BASE - (AW'(pick_idx) << 1);
  assign pc_m1     = pc_q - AW'(1);

  intr_fsm fsm_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_ent_i(start_ent),
    .start_ret_i(start_ret), .chain_i(chain), .state_o(st)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0; sp_q <= '0; vec_q <= '0;
      x_q <= '0; a_q <= '0; ccr_q <= '0;
    end else if (start_ent) begin
      pc_q <= pc_i; sp_q <= sp_i; vec_q <= vec_addr;
      x_q <= x_i; a_q <= a_i; ccr_q <= ccr_i;
    end else if (start_ret) begin
      sp_q <= sp_i;
    end else begin
      unique case (st)
        ST_E_VH:  pc_q  <= {rdata_i, pc_q[DW-1:0]};
        ST_E_VL:  pc_q  <= {pc_q[AW-1:DW], rdata_i};
        ST_R_CCR: ccr_q <= rdata_i;
        ST_R_A:   a_q   <= rdata_i;
        ST_R_X:   x_q   <= rdata_i;
        ST_R_PCH: pc_q  <= {rdata_i, pc_q[DW-1:0]};
        ST_R_PCL: pc_q  <= {pc_q[AW-1:DW], rdata_i};
        ST_R_FET: if (chain) begin
          sp_q  <= sp_q + FRAME;
          pc_q  <= pc_q + AW'(1);
          vec_q <= vec_addr;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    addr_o = '0; wdata_o = '0; rw_o = 1'b1;
    pc_ld_o = 1'b0; pc_o = '0; x_ld_o = 1'b0; x_o = '0;
    a_ld_o = 1'b0; a_o = '0; ccr_ld_o = 1'b0; ccr_o = '0;
    sp_ld_o = 1'b0; sp_o = '0; done_o = 1'b0;
    unique case (st)
      ST_E_DUM: addr_o = sp_q;
      ST_E_PCL: begin addr_o = sp_q;            rw_o = 1'b0; wdata_o = pc_m1[DW-1:0];  end
      ST_E_PCH: begin addr_o = sp_q - AW'(1);   rw_o = 1'b0; wdata_o = pc_m1[AW-1:DW]; end
      ST_E_X:   begin addr_o = sp_q - AW'(2);   rw_o = 1'b0; wdata_o = x_q;            end
      ST_E_A:   begin addr_o = sp_q - AW'(3);   rw_o = 1'b0; wdata_o = a_q;            end
      ST_E_CCR: begin
        addr_o = sp_q - AW'(4); rw_o = 1'b0; wdata_o = ccr_q;
        ccr_ld_o = 1'b1; ccr_o = ccr_q | MASK;
        sp_ld_o = 1'b1;  sp_o = sp_q - FRAME;
      end
      ST_E_VH:  addr_o = vec_q;
      ST_E_VL:  addr_o = vec_q + AW'(1);
      ST_E_FET: begin addr_o = pc_q; pc_ld_o = 1'b1; pc_o = pc_q; done_o = 1'b1; end
      ST_R_CCR: begin addr_o = sp_q + AW'(1); ccr_ld_o = 1'b1; ccr_o = rdata_i; end
      ST_R_A:   begin addr_o = sp_q + AW'(2); a_ld_o = 1'b1; a_o = rdata_i; end
      ST_R_X:   begin addr_o = sp_q + AW'(3); x_ld_o = 1'b1; x_o = rdata_i; end
      ST_R_PCH: addr_o = sp_q + AW'(4);
      ST_R_PCL: begin addr_o = sp_q + FRAME; sp_ld_o = 1'b1; sp_o = sp_q + FRAME; end
      ST_R_FET: begin
        addr_o = pc_q + AW'(1);
        if (!chain) begin pc_ld_o = 1'b1; pc_o = pc_q + AW'(1); done_o = 1'b1; end
      end
      default: ;
    endcase
  end

  assign busy_o = (st != ST_IDLE);

  assert_idle_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE && !insn_done_i && !rti_i) |=> !busy_o);

  assert_masked_no_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE && !rti_i && ccr_i[I_BIT]) |=> !busy_o);

  assert_dummy_at_sp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_E_DUM && $past(st) == ST_IDLE) |-> (rw_o && addr_o == $past(sp_i)));

  assert_mask_on_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !rw_o && sp_ld_o) |-> (ccr_ld_o && ccr_o[I_BIT]));

  assert_return_reads_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st >= ST_R_CCR) |-> rw_o);

  assert_chain_no_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain |-> !done_o);

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (busy_o && pc_ld_o) ##1 !done_o);

  assert_rti_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE && rti_i) |=> (st == ST_R_CCR));
endmodule

// File: tb/intr_stack_seq_tb.sv
`timescale 1ns/1ps
module intr_stack_seq_tb_top;
  localparam int N = 4;
  localparam logic [15:0] VB = 16'hFFFC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic insn_done = 0, rti = 0;
  logic [N-1:0] req = '0, en = '0;
  logic [15:0] pc_i = '0, sp_i = '0;
  logic [7:0] x_i = '0, a_i = '0, ccr_i = '0;
  logic [15:0] addr, pc_o, sp_o;
  logic [7:0] wdata, rdata, x_o, a_o, ccr_o;
  logic rw, pc_ld, x_ld, a_ld, ccr_ld, sp_ld, busy, done;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [15:0] sb = '0;
  logic [7:0] ov [8];

  always #2 clk = ~clk;

  intr_stack_seq #(.N_SRC(N), .VEC_BASE(VB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .insn_done_i(insn_done), .rti_i(rti),
    .irq_req_i(req), .irq_en_i(en), .pc_i(pc_i), .sp_i(sp_i),
    .x_i(x_i), .a_i(a_i), .ccr_i(ccr_i), .addr_o(addr), .wdata_o(wdata),
    .rdata_i(rdata), .rw_o(rw), .pc_ld_o(pc_ld), .pc_o(pc_o),
    .x_ld_o(x_ld), .x_o(x_o), .a_ld_o(a_ld), .a_o(a_o),
    .ccr_ld_o(ccr_ld), .ccr_o(ccr_o), .sp_ld_o(sp_ld), .sp_o(sp_o),
    .busy_o(busy), .done_o(done)
  );

  function automatic logic [7:0] hsh(input logic [15:0] a);
    logic [7:0] m;
    m = a[15:8] * 8'd13;
    return a[7:0] ^ m ^ 8'hA5;
  endfunction

  logic [15:0] roff;
  always_comb begin
    roff  = addr - sb;
    rdata = (roff < 16'd8) ? ov[roff[2:0]] : hsh(addr);
  end

  function automatic logic [7:0] rd(input logic [15:0] a);
    logic [15:0] o;
    o = a - sb;
    if (o < 16'd8) return ov[o[2:0]];
    return hsh(a);
  endfunction

  function automatic int exp_src(input logic [N-1:0] r, input logic [N-1:0] e);
    for (int i = 0; i < N; i++) if (r[i] && e[i]) return i;
    return -1;
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic idle_chk(input string rq);
    chk(rq, {busy, done, rw, addr}, {1'b0, 1'b0, 1'b1, 16'h0});
  endtask

  task automatic start_entry(input logic [15:0] pc, input logic [15:0] sp,
                             input logic [7:0] x, input logic [7:0] a, input logic [7:0] c);
    pc_i = pc; sp_i = sp; x_i = x; a_i = a; ccr_i = c; insn_done = 1;
    @(negedge clk);
    insn_done = 0;
  endtask

  // called at the negedge where the dummy cycle is on the bus
  task automatic exp_entry(input logic [15:0] pc, input logic [15:0] sp, input logic [7:0] x,
                           input logic [7:0] a, input logic [7:0] c, input int src,
                           input string wt);
    logic [15:0] pm1, vec, hpc, ea, o;
    logic [7:0] ewd;
    logic erw;
    pm1 = pc - 16'd1;
    vec = VB - 16'(src * 2);
    hpc = '0;
    for (int k = 0; k < 9; k++) begin
      erw = 1'b1; ewd = 8'h00;
      case (k)
        0: ea = sp;
        1: begin ea = sp;          erw = 0; ewd = pm1[7:0];  end
        2: begin ea = sp - 16'd1;  erw = 0; ewd = pm1[15:8]; end
        3: begin ea = sp - 16'd2;  erw = 0; ewd = x;         end
        4: begin ea = sp - 16'd3;  erw = 0; ewd = a;         end
        5: begin ea = sp - 16'd4;  erw = 0; ewd = c;         end
        6: begin ea = vec;         hpc[15:8] = rd(vec);      end
        7: begin ea = vec + 16'd1; hpc[7:0] = rd(vec + 16'd1); end
        default: ea = hpc;
      endcase
      chk((k < 6) ? wt : (k < 8) ? "R3" : "R5", {7'd0, rw, wdata, addr}, {7'd0, erw, ewd, ea});
      chk("R9 busy", {31'd0, busy}, 32'd1);
      chk("R9 done", {31'd0, done}, {31'd0, (k == 8)});
      if (k == 5) begin
        chk("R6 ccr", {23'd0, ccr_ld, ccr_o}, {23'd0, 1'b1, c | 8'h08});
        chk("R6 sp", {15'd0, sp_ld, sp_o}, {15'd0, 1'b1, sp - 16'd5});
      end
      if (k == 8) chk("R5 pc", {15'd0, pc_ld, pc_o}, {15'd0, 1'b1, hpc});
      if (!erw) begin
        o = ea - sb;
        if (o < 16'd8) ov[o[2:0]] = ewd;
      end
      @(negedge clk);
    end
  endtask

  task automatic exp_return(input logic [15:0] sp, input bit chain_exp,
                            output logic [15:0] rpc, output logic [7:0] rc,
                            output logic [7:0] rx, output logic [7:0] ra);
    logic [15:0] fa;
    rc = '0; rx = '0; ra = '0;
    fa = {rd(sp + 16'd4), rd(sp + 16'd5)} + 16'd1;
    rpc = fa;
    for (int k = 0; k < 6; k++) begin
      if (k < 5) chk("R7 addr", {15'd0, rw, addr}, {15'd0, 1'b1, sp + 16'(k + 1)});
      else       chk("R7 fetch", {15'd0, rw, addr}, {15'd0, 1'b1, fa});
      chk("R9 busy", {31'd0, busy}, 32'd1);
      case (k)
        0: begin chk("R7 ccr", {23'd0, ccr_ld, ccr_o}, {23'd0, 1'b1, rd(sp + 16'd1)}); rc = ccr_o; end
        1: begin chk("R7 a", {23'd0, a_ld, a_o}, {23'd0, 1'b1, rd(sp + 16'd2)}); ra = a_o; end
        2: begin chk("R7 x", {23'd0, x_ld, x_o}, {23'd0, 1'b1, rd(sp + 16'd3)}); rx = x_o; end
        4: chk("R7 sp", {15'd0, sp_ld, sp_o}, {15'd0, 1'b1, sp + 16'd5});
        5: if (chain_exp) chk("R8 no done", {31'd0, done}, 32'd0);
           else chk("R7 done pc", {14'd0, done, pc_ld, pc_o}, {14'd0, 1'b1, 1'b1, fa});
        default: chk("R9 done", {31'd0, done}, 32'd0);
      endcase
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] pc, sp, rpc;
    logic [7:0] x, a, c, rc, rx, ra;
    int s, seed;
    seed = $urandom(32'h5EED);
    for (int i = 0; i < 8; i++) ov[i] = 8'h00;

    repeat (3) @(negedge clk);
    idle_chk("R1 reset");
    rst_n = 1;
    @(negedge clk);

    req = 4'b1111; en = 4'b1111;
    repeat (3) begin @(negedge clk); idle_chk("R1 no boundary"); end

    start_entry(16'h1234, 16'h0200, 8'h11, 8'h22, 8'h08);
    idle_chk("R2 masked");
    req = 4'b1111; en = 4'b0000;
    start_entry(16'h1234, 16'h0200, 8'h11, 8'h22, 8'h00);
    idle_chk("R2 disabled");
    req = 4'b0000; en = 4'b1111;
    start_entry(16'h1234, 16'h0200, 8'h11, 8'h22, 8'h00);
    idle_chk("R2 no request");

    // priority: sources 1 and 3 pending
    req = 4'b1010; en = 4'b1111; sb = 16'h01FC;
    start_entry(16'h4321, 16'h0200, 8'h5A, 8'hC3, 8'hF1);
    exp_entry(16'h4321, 16'h0200, 8'h5A, 8'hC3, 8'hF1, 1, "R4");
    idle_chk("R9 after entry");

    // wrap around zero
    req = 4'b0100; en = 4'b0100; sb = 16'hFFFE;
    start_entry(16'h0000, 16'h0002, 8'h77, 8'h88, 8'h00);
    exp_entry(16'h0000, 16'h0002, 8'h77, 8'h88, 8'h00, 2, "R10");
    idle_chk("R10 after entry");

    // random round trips; odd iterations chain back in
    for (int it = 0; it < 24; it++) begin
      pc = 16'($urandom); sp = 16'h0100 + 16'($urandom % 32'h7000);
      x = 8'($urandom); a = 8'($urandom); c = 8'($urandom) & 8'hF7;
      en = N'($urandom); req = N'($urandom);
      if ((req & en) == '0) begin en[N-1] = 1'b1; req = en; end
      s = exp_src(req, en);
      sb = sp - 16'd4;
      start_entry(pc, sp, x, a, c);
      exp_entry(pc, sp, x, a, c, s, "R4");
      if (it % 2 == 0) en = '0;
      start_entry(16'h0, 16'h0, 8'h0, 8'h0, 8'h08);
      pc_i = '0;
      sp_i = sp - 16'd5; rti = 1;
      @(negedge clk);
      rti = 0;
      exp_return(sp - 16'd5, (it % 2 == 1), rpc, rc, rx, ra);
      chk("R7 pc roundtrip", {16'd0, rpc}, {16'd0, pc});
      chk("R7 regs roundtrip", {8'd0, rc, rx, ra}, {8'd0, c, x, a});
      if (it % 2 == 1) exp_entry(pc, sp, x, a, c, s, "R8");
      idle_chk("R9 after sequence");
    end

    // restored mask set: no chain even with a pending request
    req = 4'b0001; en = 4'b0001; sb = 16'h0301;
    ov[0] = 8'h0C; ov[1] = 8'h33; ov[2] = 8'h44; ov[3] = 8'h9A; ov[4] = 8'hBC;
    sp_i = 16'h0300; rti = 1;
    @(negedge clk);
    rti = 0;
    exp_return(16'h0300, 1'b0, rpc, rc, rx, ra);
    chk("R8 masked restore pc", {16'd0, rpc}, {16'd0, 16'h9ABD});
    idle_chk("R8 after return");

    // rti and boundary together, unmasked request pending
    ov[0] = 8'h08;
    sp_i = 16'h0300; ccr_i = 8'h00; rti = 1; insn_done = 1;
    @(negedge clk);
    rti = 0; insn_done = 0;
    exp_return(16'h0300, 1'b0, rpc, rc, rx, ra);
    chk("R11 return chosen", {16'd0, rpc}, {16'd0, 16'h9ABD});
    idle_chk("R11 after return");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule